// File: doc/BRIEF.md
# Opcode-Driven Integer ALU

This block is a purely combinational 32-bit arithmetic and logic unit. It takes the 6-bit operation code straight from an instruction word, with no separate decode stage. It also takes two register operands, called B and C, and the 16-bit immediate field. From these it produces a result, a zero flag and an illegal-operation flag, all in the same cycle.

Bits [5:1] of the code choose the operation. Bit 0 chooses the second operand: when it is 0 the block uses register C, and when it is 1 it uses the immediate, sign-extended to 32 bits. Comparisons, division and remainder treat both operands as signed two's complement. Division by zero never traps; it returns a fixed result instead.

Top module: `opcode_alu`

## Requirements
- R1: Code 000000 gives B+C and code 000010 gives B-C, both modulo 2^32.
- R2: Code 000100 gives B|C and code 000110 gives B&C, bit by bit.
- R3: The signed compares output 1 when their condition is true and 0 otherwise: B>C for code 001000, B<C for code 001010 and B==C for code 001100.
- R4: Code 001110 gives the low 32 bits of B*C.
- R5: Code 010000 gives the signed quotient B/C, rounded toward zero. Code 010010 gives the signed remainder, whose sign follows B. For B=0x80000000 and C=-1, the quotient is 0x80000000 and the remainder is 0.
- R6: When C is 0, the quotient is 0xFFFFFFFF and the remainder is B.
- R7: Code 100010 outputs ~B. Its result does not depend on C or the immediate, and code 100011 behaves the same way.
- R8: When bit 0 of the code is 1, C is replaced by the 16-bit immediate, sign-extended from bit 15. This applies to every operation listed in R1 to R6.
- R9: The zero output is 1 exactly when the 32-bit result is 0.
- R10: Any code not listed in R1 to R8 sets the illegal output to 1 and forces the result to 0. Examples are 100000, 010100 and 111111. A listed code clears the illegal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 6 | Operation code; bit 0 selects the immediate |
| src_b | input | 32 | First register operand |
| src_c | input | 32 | Second register operand |
| imm | input | 16 | Immediate field of the instruction |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is 0 |
| illegal | output | 1 | High for an undefined operation code |

## Verification
Several properties are checked whenever the inputs change. These are: an illegal code forces a zero result, compares produce only 0 or 1, the inverse op is exactly the complement of B, a sum can be reversed back to its operand, and the zero flag agrees with the result. The exact arithmetic needs the bench's vectors to show it. This covers sign extension of the immediate, truncated signed quotients and remainders, the most-negative-by-minus-one case and the divide-by-zero fallbacks.

// File: rtl/opcode_alu.sv
module opcode_alu #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [5:0]       op,
  input  logic [W-1:0]     src_b,
  input  logic [W-1:0]     src_c,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     result,
  output logic             zero,
  output logic             illegal
);
  localparam logic [4:0] K_ADD = 5'b00000;
  localparam logic [4:0] K_SUB = 5'b00001;
  localparam logic [4:0] K_OR  = 5'b00010;
  localparam logic [4:0] K_AND = 5'b00011;
  localparam logic [4:0] K_SGT = 5'b00100;
  localparam logic [4:0] K_SLT = 5'b00101;
  localparam logic [4:0] K_SEQ = 5'b00110;
  localparam logic [4:0] K_MUL = 5'b00111;
  localparam logic [4:0] K_DIV = 5'b01000;
  localparam logic [4:0] K_REM = 5'b01001;
  localparam logic [4:0] K_NOT = 5'b10001;
  localparam int EXT_W = W - IMM_W;

  logic [4:0]   key;
  logic [W-1:0] opnd;
  logic         b_neg, c_neg;
  logic [W-1:0] mag_b, mag_c, q_mag, r_mag, quot, rem;
  logic [2*W-1:0] prod;

  assign key  = op[5:1];
  assign opnd = op[0] ? {{EXT_W{imm[IMM_W-1]}}, imm} : src_c;

  assign b_neg = src_b[W-1];
  assign c_neg = opnd[W-1];
  assign mag_b = b_neg ? (~src_b + 1'b1) : src_b;
  assign mag_c = c_neg ? (~opnd + 1'b1) : opnd;
  assign q_mag = (mag_c == '0) ? '0 : mag_b / mag_c;
  assign r_mag = (mag_c == '0) ? '0 : mag_b % mag_c;
  assign quot  = (opnd == '0) ? '1 :
                 ((b_neg ^ c_neg) ? (~q_mag + 1'b1) : q_mag);
  assign rem   = (opnd == '0) ? src_b :
                 (b_neg ? (~r_mag + 1'b1) : r_mag);
  assign prod  = src_b * opnd;

  always_comb begin
    illegal = 1'b0;
    unique case (key)
      K_ADD:   result = src_b + opnd;
      K_SUB:   result = src_b - opnd;
      K_OR:    result = src_b | opnd;
      K_AND:   result = src_b & opnd;
      K_SGT:   result = W'($signed(src_b) > $signed(opnd));
      K_SLT:   result = W'($signed(src_b) < $signed(opnd));
      K_SEQ:   result = W'(src_b == opnd);
      K_MUL:   result = prod[W-1:0];
      K_DIV:   result = quot;
      K_REM:   result = rem;
      K_NOT:   result = ~src_b;
      default: begin
        result  = '0;
        illegal = 1'b1;
      end
    endcase
  end

  assign zero = (result == '0);

  always_comb begin
    // R10
    illegal_zero_chk: assert (!illegal || (result == '0 && zero));
    // R3
    compare_bool_chk: assert (!(key == K_SGT || key == K_SLT || key == K_SEQ) || result[W-1:1] == '0);
    // R7
    invert_chk: assert (key != K_NOT || (result ^ src_b) == '1);
    // R1
    add_reverse_chk: assert (key != K_ADD || (result - src_b) == opnd);
    // R9
    zero_flag_chk: assert (zero == ~|result);
  end
endmodule

// File: tb/opcode_alu_bench.sv
module opcode_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0]  op;
  logic [31:0] src_b, src_c, result;
  logic [15:0] imm;
  logic        zero, illegal;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opcode_alu u_opcode_alu (
    .op(op), .src_b(src_b), .src_c(src_c), .imm(imm),
    .result(result), .zero(zero), .illegal(illegal)
  );

  // {op, b, c, imm, expected result, expected illegal}
  localparam logic [118:0] TBL [NV] = '{
    {6'b000000, 32'h00000005, 32'h00000007, 16'h0000, 32'h0000000C, 1'b0}, // R1
    {6'b000001, 32'h0000000A, 32'h00000000, 16'hFFFF, 32'h00000009, 1'b0}, // R1 R8
    {6'b000010, 32'h00000003, 32'h00000005, 16'h0000, 32'hFFFFFFFE, 1'b0}, // R1
    {6'b000011, 32'h00000064, 32'h12345678, 16'h0064, 32'h00000000, 1'b0}, // R1 R8 R9
    {6'b000100, 32'hF0F00000, 32'h00000F0F, 16'h0000, 32'hF0F00F0F, 1'b0}, // R2
    {6'b000101, 32'h00010000, 32'h00000000, 16'h8001, 32'hFFFF8001, 1'b0}, // R2 R8
    {6'b000110, 32'hFF00FF00, 32'h0F0F0F0F, 16'h0000, 32'h0F000F00, 1'b0}, // R2
    {6'b000111, 32'h12345678, 32'hFFFFFFFF, 16'h00FF, 32'h00000078, 1'b0}, // R2 R8
    {6'b001000, 32'h00000001, 32'hFFFFFFFF, 16'h0000, 32'h00000001, 1'b0}, // R3
    {6'b001001, 32'hFFFFFFFE, 32'h00000000, 16'hFFFF, 32'h00000000, 1'b0}, // R3 R8
    {6'b001010, 32'h80000000, 32'h7FFFFFFF, 16'h0000, 32'h00000001, 1'b0}, // R3
    {6'b001011, 32'h00000005, 32'h00000009, 16'h0005, 32'h00000000, 1'b0}, // R3 R8
    {6'b001100, 32'hDEADBEEF, 32'hDEADBEEF, 16'h0000, 32'h00000001, 1'b0}, // R3
    {6'b001101, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 32'h00000001, 1'b0}, // R3 R8
    {6'b001110, 32'h00010000, 32'h00010000, 16'h0000, 32'h00000000, 1'b0}, // R4 R9
    {6'b001111, 32'h00000007, 32'h00000000, 16'hFFFD, 32'hFFFFFFEB, 1'b0}, // R4 R8
    {6'b010000, 32'hFFFFFFF9, 32'h00000002, 16'h0000, 32'hFFFFFFFD, 1'b0}, // R5
    {6'b010001, 32'h00000064, 32'h00000000, 16'hFFF6, 32'hFFFFFFF6, 1'b0}, // R5 R8
    {6'b010010, 32'hFFFFFFF9, 32'h00000002, 16'h0000, 32'hFFFFFFFF, 1'b0}, // R5
    {6'b010011, 32'h00000011, 32'h00000000, 16'h0005, 32'h00000002, 1'b0}, // R5 R8
    {6'b010000, 32'h80000000, 32'hFFFFFFFF, 16'h0000, 32'h80000000, 1'b0}, // R5
    {6'b010010, 32'h80000000, 32'hFFFFFFFF, 16'h0000, 32'h00000000, 1'b0}, // R5
    {6'b010000, 32'h00000005, 32'h00000000, 16'h0000, 32'hFFFFFFFF, 1'b0}, // R6
    {6'b010010, 32'hFFFFFFF7, 32'h00000000, 16'h0000, 32'hFFFFFFF7, 1'b0}, // R6
    {6'b010001, 32'h00000005, 32'h00000009, 16'h0000, 32'hFFFFFFFF, 1'b0}, // R6 R8
    {6'b100010, 32'h0F0F0F0F, 32'h00000000, 16'h0000, 32'hF0F0F0F0, 1'b0}, // R7
    {6'b100010, 32'h0F0F0F0F, 32'hFFFFFFFF, 16'h1234, 32'hF0F0F0F0, 1'b0}, // R7
    {6'b100011, 32'h00000000, 32'h55555555, 16'h1234, 32'hFFFFFFFF, 1'b0}, // R7
    {6'b100000, 32'h00000005, 32'h00000007, 16'h0000, 32'h00000000, 1'b1}, // R10
    {6'b010100, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 32'h00000000, 1'b1}, // R10
    {6'b111111, 32'h12345678, 32'h00000001, 16'h0001, 32'h00000000, 1'b1}, // R10
    {6'b110000, 32'h00000001, 32'h00000001, 16'h0000, 32'h00000000, 1'b1}  // R10
  };

  task automatic check(input string req, input logic [31:0] exp_r, input logic exp_ill);
    logic exp_z;
    exp_z = (exp_r == 32'h0);
    n_chk++;
    if (result !== exp_r || illegal !== exp_ill || zero !== exp_z) begin
      n_bad++;
      $display("FAIL %s op=%b result=%h zero=%b illegal=%b expected result=%h zero=%b illegal=%b",
               req, op, result, zero, illegal, exp_r, exp_z, exp_ill);
    end
  endtask

  task automatic apply(input logic [5:0] o, input logic [31:0] b, input logic [31:0] c,
                       input logic [15:0] i);
    @(posedge clk);
    op = o; src_b = b; src_c = c; imm = i;
    @(negedge clk);
  endtask

  initial begin
    op = '0; src_b = '0; src_c = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset", 32'h0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      apply(TBL[k][118:113], TBL[k][112:81], TBL[k][80:49], TBL[k][48:33]);
      check("R1-table", TBL[k][32:1], TBL[k][0]);
    end

    // R1 wraparound
    apply(6'b000000, 32'hFFFFFFFF, 32'h00000001, 16'h0);
    check("R1 wrap", 32'h0, 1'b0);
    // R8 register ignored when immediate selected
    apply(6'b000001, 32'h00000001, 32'h7FFFFFFF, 16'h0002);
    check("R8 imm", 32'h00000003, 1'b0);
    // R10 legal code after illegal clears flag
    apply(6'b100110, 32'h1, 32'h1, 16'h1);
    check("R10 illegal", 32'h0, 1'b1);
    apply(6'b000100, 32'h0, 32'h0, 16'h0);
    check("R10 clear R9", 32'h0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule